// File: doc/BRIEF.md
# Clock-Calendar Serial Register Front End

This block is the two-wire serial slave that sits in front of an eight-byte clock and calendar register file. It oversamples the bus clock and data lines with the system clock and filters them. It recognises START and STOP conditions, answers only to its fixed 7-bit device address, and moves bytes between the bus and the register file through a 3-bit auto-incrementing pointer. A write access loads the pointer from its first byte and stores every later byte at the pointer. A read access returns bytes from the pointer, either after a pointer write and a repeated START or straight away from wherever the pointer was left.

While the bus is selected and the pointer names one of the time-keeping registers (0 to 6), the block raises `freeze` so that the calendar holds its user-visible copy steady. A power-fail input aborts any access, clears the pointer and blocks the bus. The bus stays blocked for a recovery window after power-fail goes away. The register storage and the time-keeping logic sit outside this block.

The controller has nine states. `ST_IDLE` ignores bus bits until a START. `ST_DEV` shifts in the device byte. `ST_DEV_ACK` acknowledges it. `ST_PTR` shifts in the pointer byte and `ST_PTR_ACK` acknowledges it. `ST_WDATA` shifts in a data byte and `ST_WACK` acknowledges it. `ST_RDATA` shifts a byte out and `ST_RACK` samples the master's acknowledge. A START moves any state to `ST_DEV`. A STOP or power-fail moves any state to `ST_IDLE`. `ST_DEV` goes to `ST_DEV_ACK` on an address match and to `ST_IDLE` otherwise. `ST_DEV_ACK` goes to `ST_RDATA` for a read and to `ST_PTR` for a write. `ST_PTR_ACK` goes to `ST_WDATA`. `ST_WDATA` and `ST_WACK` alternate. `ST_RDATA` goes to `ST_RACK`. `ST_RACK` goes back to `ST_RDATA` on an acknowledge and to `ST_IDLE` on a NACK.

Top module: `rtc_i2c_front`

## Requirements
- R1: Only a device byte whose upper seven bits are 1101000 is acknowledged (bit 0 = 0 selects write, 1 selects read, so D0h and D1h). Any other address gets no acknowledge, and the bytes that follow cause no register write.
- R2: In a write access, the first byte after the device byte is acknowledged, and its low three bits load the pointer that appears on `reg_addr`.
- R3: Each further write byte is acknowledged and produces a one-cycle `reg_we` with `reg_addr` equal to the pointer. The pointer then increments on the acknowledge clock of that byte.
- R4: After a pointer write and a repeated START with D1h, the block sends the byte at the pointer MSB first, with a low bit driven as `sda_oe`=1. Each following byte comes from the next address, because the pointer increments on every acknowledge clock of a read byte.
- R5: A read that begins without a pointer write starts at the address left in the pointer by the previous access.
- R6: When the master NACKs a read byte, the block stops driving SDA and stays released until the next START.
- R7: The pointer wraps from 7 to 0.
- R8: `freeze` is 1 while the block is selected by a matched address and the pointer is 0 to 6. It is 0 when the pointer is 7, and it is cleared by STOP.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP in the middle of a byte abandons that byte with no write. A START restarts address reception from any state.
- R10: While `pwr_fail` is 1, the transfer is aborted, the pointer is 0, `freeze` and `sda_oe` are 0, and no write occurs.
- R11: After `pwr_fail` falls, the bus is ignored for RECOVER_US microseconds (500 system clocks at the defaults). A START inside this window is not seen.
- R12: `sda_oe` only becomes asserted while the filtered SCL is low.
- R13: After reset, `sda_oe`, `reg_we` and `freeze` are 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pwr_fail | input | 1 | Supply-out-of-tolerance indication, synchronous |
| reg_rdata | input | 8 | Register file contents at `reg_addr` |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_we | output | 1 | One-cycle write strobe to the register file |
| reg_addr | output | 3 | Current pointer, register file address |
| reg_wdata | output | 8 | Byte to write, valid with `reg_we` |
| freeze | output | 1 | Hold the calendar's user copy steady |

## Verification
A wrong pointer shows up on `reg_addr` within a few system clocks of the acknowledge clock, and then as the wrong byte on the next read or the wrong write location. A wrong state shows up at the next bus bit as an acknowledge that is missing or unexpected, as SDA driven during a bit the master owns, or as a data bit out of order. A bad selection or power state shows on `freeze` and `sda_oe` in the cycle after the STOP or power-fail. Each directed scenario therefore checks acknowledges, read data, the bench's register model and these outputs right after the bus event that should change them.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } xfer_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                level_q;
    logic                rise_q;
    logic                fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            hist_q  <= '1;
            level_q <= 1'b1;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (&hist_q && !level_q) begin
                level_q <= 1'b1;
                rise_q  <= 1'b1;
            end else if (~|hist_q && level_q) begin
                level_q <= 1'b0;
                fall_q  <= 1'b1;
            end
        end
    end

    assign level_o = level_q;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard #(
    parameter int unsigned REC_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail,
    output logic bus_en
);

    localparam int unsigned CNT_W = $clog2(REC_CYCLES + 1);

    logic [CNT_W-1:0] rec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (pwr_fail) begin
            rec_q <= CNT_W'(REC_CYCLES);
        end else if (rec_q != '0) begin
            rec_q <= rec_q - 1'b1;
        end
    end

    assign bus_en = !pwr_fail && (rec_q == '0);

    // R11: the cycle power-fail drops, the bus is still blocked
    assert_recover_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_fail) |-> !bus_en);

endmodule

// File: rtl/reg_pointer.sv
module reg_pointer #(
    parameter int unsigned PTR_W       = 3,
    parameter int unsigned FREEZE_LAST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    input  logic             sel_set,
    input  logic             sel_clr,
    output logic [PTR_W-1:0] ptr_o,
    output logic             freeze_o
);

    logic [PTR_W-1:0] ptr_q;
    logic             sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            sel_q <= 1'b0;
        end else if (clr) begin
            ptr_q <= '0;
            sel_q <= 1'b0;
        end else begin
            if (load) begin
                ptr_q <= load_val;
            end else if (inc) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (sel_clr) begin
                sel_q <= 1'b0;
            end else if (sel_set) begin
                sel_q <= 1'b1;
            end
        end
    end

    assign ptr_o    = ptr_q;
    assign freeze_o = sel_q && (ptr_q <= PTR_W'(FREEZE_LAST));

    // R7: an increment from the top address lands on zero
    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !clr && ptr_q == '1) |=> ptr_q == '0);

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import rtc_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              start,
    input  logic              stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ptr_ld,
    output logic              ptr_inc,
    output logic              sel_set,
    output logic              sel_clr
);

    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

    xfer_state_t       state_q, state_d;
    logic [CNT_W-1:0]  bit_q, bit_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic              oe_q, oe_d;
    logic              byte_done;

    assign byte_done = scl_fall && (bit_q == CNT_W'(BYTE_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            oe_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            tx_q    <= tx_d;
            oe_q    <= oe_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        tx_d    = tx_q;
        oe_d    = oe_q;
        reg_we  = 1'b0;
        ptr_ld  = 1'b0;
        ptr_inc = 1'b0;
        sel_set = 1'b0;
        sel_clr = 1'b0;
        if (!bus_en) begin
            state_d = ST_IDLE;
            bit_d   = '0;
            oe_d    = 1'b0;
            sel_clr = 1'b1;
        end else if (start) begin
            state_d = ST_DEV;
            bit_d   = '0;
            oe_d    = 1'b0;
        end else if (stop) begin
            state_d = ST_IDLE;
            bit_d   = '0;
            oe_d    = 1'b0;
            sel_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    oe_d = 1'b0;
                end
                ST_DEV, ST_PTR, ST_WDATA: begin
                    if (scl_rise && bit_q < CNT_W'(BYTE_W)) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
                        bit_d = bit_q + 1'b1;
                    end else if (byte_done) begin
                        bit_d = '0;
                        if (state_q == ST_DEV) begin
                            if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                                state_d = ST_DEV_ACK;
                                oe_d    = 1'b1;
                                sel_set = 1'b1;
                            end else begin
                                state_d = ST_IDLE;
                                sel_clr = 1'b1;
                            end
                        end else if (state_q == ST_PTR) begin
                            state_d = ST_PTR_ACK;
                            oe_d    = 1'b1;
                            ptr_ld  = 1'b1;
                        end else begin
                            state_d = ST_WACK;
                            oe_d    = 1'b1;
                            reg_we  = 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_d = '0;
                        if (sh_q[0]) begin
                            state_d = ST_RDATA;
                            tx_d    = reg_rdata;
                            oe_d    = !reg_rdata[BYTE_W-1];
                        end else begin
                            state_d = ST_PTR;
                            oe_d    = 1'b0;
                        end
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                        bit_d   = '0;
                        oe_d    = 1'b0;
                    end
                end
                ST_WACK: begin
                    if (scl_rise) begin
                        ptr_inc = 1'b1;
                    end
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                        bit_d   = '0;
                        oe_d    = 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_q == CNT_W'(BYTE_W - 1)) begin
                            state_d = ST_RACK;
                            bit_d   = '0;
                            oe_d    = 1'b0;
                        end else begin
                            tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
                            oe_d  = !tx_q[BYTE_W-2];
                            bit_d = bit_q + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ptr_inc = 1'b1;
                        sh_d    = {sh_q[BYTE_W-1:1], sda_lvl};
                    end
                    if (scl_fall) begin
                        bit_d = '0;
                        if (!sh_q[0]) begin
                            state_d = ST_RDATA;
                            tx_d    = reg_rdata;
                            oe_d    = !reg_rdata[BYTE_W-1];
                        end else begin
                            state_d = ST_IDLE;
                            oe_d    = 1'b0;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

    assign sda_oe  = oe_q;
    assign rx_byte = sh_q;

    // R12: the slave only starts pulling SDA while SCL is low
    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !scl_lvl);

    // R6: after a NACKed read byte the line stays released
    assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !oe_q);

endmodule

// File: rtl/rtc_i2c_front.sv
module rtc_i2c_front #(
    parameter logic [6:0]  DEV_ADDR    = 7'h68,
    parameter int unsigned CLK_MHZ     = 50,
    parameter int unsigned RECOVER_US  = 10,
    parameter int unsigned FILT_LEN    = 3,
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned FREEZE_LAST = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       pwr_fail,
    input  logic [7:0] reg_rdata,
    output logic       sda_oe,
    output logic       reg_we,
    output logic [2:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       freeze
);

    localparam int unsigned PTR_W      = $clog2(NUM_REGS);
    localparam int unsigned REC_CYCLES = CLK_MHZ * RECOVER_US;
    localparam int unsigned N_LINES    = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_lvl;
    logic [N_LINES-1:0] line_rise;
    logic [N_LINES-1:0] line_fall;

    logic             bus_en;
    logic             start;
    logic             stop;
    logic             ptr_ld;
    logic             ptr_inc;
    logic             sel_set;
    logic             sel_clr;
    logic [7:0]       rx_byte;
    logic [PTR_W-1:0] ptr;

    assign line_raw = {sda_i, scl_i};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_raw[gi]),
            .level_o(line_lvl[gi]),
            .rise_o (line_rise[gi]),
            .fall_o (line_fall[gi])
        );
    end

    assign start = line_fall[1] && line_lvl[0];
    assign stop  = line_rise[1] && line_lvl[0];

    pwr_guard #(.REC_CYCLES(REC_CYCLES)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_fail(pwr_fail),
        .bus_en  (bus_en)
    );

    i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .start    (start),
        .stop     (stop),
        .scl_rise (line_rise[0]),
        .scl_fall (line_fall[0]),
        .scl_lvl  (line_lvl[0]),
        .sda_lvl  (line_lvl[1]),
        .reg_rdata(reg_rdata),
        .sda_oe   (sda_oe),
        .reg_we   (reg_we),
        .rx_byte  (rx_byte),
        .ptr_ld   (ptr_ld),
        .ptr_inc  (ptr_inc),
        .sel_set  (sel_set),
        .sel_clr  (sel_clr)
    );

    reg_pointer #(.PTR_W(PTR_W), .FREEZE_LAST(FREEZE_LAST)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!bus_en),
        .load    (ptr_ld),
        .load_val(rx_byte[PTR_W-1:0]),
        .inc     (ptr_inc),
        .sel_set (sel_set),
        .sel_clr (sel_clr),
        .ptr_o   (ptr),
        .freeze_o(freeze)
    );

    assign reg_addr  = 3'(ptr);
    assign reg_wdata = rx_byte;

    // R10: power-fail clears pointer, drive and freeze by the next cycle
    assert_pwr_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!sda_oe && reg_addr == 3'd0 && !freeze));

    // R3: one strobe per received byte
    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R11: no write while the guard blocks the bus
    assert_no_write_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> !reg_we);

endmodule

// File: tb/rtc_i2c_front_test.sv
module rtc_i2c_front_test;

    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       pwr_fail = 1'b0;
    logic [7:0] reg_rdata;
    logic       sda_oe;
    logic       reg_we;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       freeze;
    logic       sda_line;
    logic [7:0] regs [8];
    int         wr_count = 0;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    int         oe_bad = 0;
    logic       oe_prev = 1'b0;

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    rtc_i2c_front uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .pwr_fail (pwr_fail),
        .reg_rdata(reg_rdata),
        .sda_oe   (sda_oe),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .freeze   (freeze)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) regs[i] <= 8'h40 + 8'(i);
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    always @(posedge clk) begin
        oe_prev <= sda_oe;
        if (rst_n && sda_oe && !oe_prev && scl) oe_bad <= oe_bad + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected < 150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b; wq(Q);
        scl = 1'b1; wq(Q);
        seen = sda_line; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        send_bits(b, 8);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(nack, s);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        check("R13 sda_oe", 32'(sda_oe), 0);
        check("R13 reg_we", 32'(reg_we), 0);
        check("R13 freeze", 32'(freeze), 0);
        check("R13 reg_addr", 32'(reg_addr), 0);
    endtask

    task automatic t_write_seq();
        logic a;
        bus_start();
        send_byte(8'hD0, a); check("R1 ack D0", 32'(a), 1);
        send_byte(8'h02, a); check("R2 ptr ack", 32'(a), 1);
        check("R2 reg_addr", 32'(reg_addr), 2);
        send_byte(8'hA5, a); check("R3 ack data", 32'(a), 1);
        send_byte(8'h3C, a); check("R3 ack data2", 32'(a), 1);
        check("R3 regs2", 32'(regs[2]), 32'hA5);
        check("R3 regs3", 32'(regs[3]), 32'h3C);
        check("R3 ptr incr", 32'(reg_addr), 4);
        check("R3 wr count", 32'(wr_count), 2);
        check("R8 freeze on", 32'(freeze), 1);
        bus_stop();
        check("R8 freeze off at stop", 32'(freeze), 0);
    endtask

    task automatic t_read_rs();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h02, a);
        bus_start();
        send_byte(8'hD1, a); check("R4 ack D1", 32'(a), 1);
        recv_byte(1'b0, d); check("R4 first byte", 32'(d), 32'hA5);
        recv_byte(1'b1, d); check("R4 next byte", 32'(d), 32'h3C);
        wq(Q);
        check("R6 released after nack", 32'(sda_oe), 0);
        recv_byte(1'b1, d); check("R6 no drive after nack", 32'(d), 32'hFF);
        bus_stop();
        check("R3 no stray write", 32'(wr_count), 2);
    endtask

    task automatic t_current_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD1, a); check("R5 ack", 32'(a), 1);
        recv_byte(1'b1, d); check("R5 current addr byte", 32'(d), 32'h44);
        bus_stop();
        check("R5 ptr after", 32'(reg_addr), 5);
    endtask

    task automatic t_wrap_freeze();
        logic a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h05, a);
        check("R8 freeze ptr5", 32'(freeze), 1);
        send_byte(8'h11, a);
        check("R8 freeze ptr6", 32'(freeze), 1);
        send_byte(8'h22, a);
        check("R8 freeze ptr7 off", 32'(freeze), 0);
        send_byte(8'h33, a);
        check("R7 wrap", 32'(reg_addr), 0);
        check("R8 freeze back on", 32'(freeze), 1);
        check("R7 regs7", 32'(regs[7]), 32'h33);
        bus_stop();
        check("R8 stop clears", 32'(freeze), 0);
    endtask

    task automatic t_bad_addr();
        logic a;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(8'hA0, a); check("R1 no ack", 32'(a), 0);
        send_byte(8'h01, a); check("R1 ignored byte", 32'(a), 0);
        send_byte(8'h99, a);
        check("R1 freeze off", 32'(freeze), 0);
        bus_stop();
        check("R1 no write", 32'(wr_count), 32'(w0));
    endtask

    task automatic t_stop_abort();
        logic a;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h01, a);
        send_bits(8'hF0, 4);
        bus_stop();
        check("R9 no write on stop", 32'(wr_count), 32'(w0));
        check("R9 regs1 kept", 32'(regs[1]), 32'h41);
        check("R9 released", 32'(sda_oe), 0);
        bus_start();
        send_byte(8'hD0, a); check("R9 restart ack", 32'(a), 1);
        bus_stop();
    endtask

    task automatic t_power();
        logic a;
        logic [7:0] d;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h03, a);
        send_bits(8'h5A, 4);
        pwr_fail = 1'b1; wq(4);
        check("R10 ptr cleared", 32'(reg_addr), 0);
        check("R10 sda released", 32'(sda_oe), 0);
        check("R10 freeze off", 32'(freeze), 0);
        send_bits(8'h5A, 4);
        clk_bit(1'b1, a);
        check("R10 no ack", 32'(!a), 0);
        check("R10 no write", 32'(wr_count), 32'(w0));
        pwr_fail = 1'b0;
        bus_stop();
        bus_start();
        send_byte(8'hD1, a); check("R11 ignored in window", 32'(a), 0);
        bus_stop();
        wq(600);
        bus_start();
        send_byte(8'hD1, a); check("R11 accepted after window", 32'(a), 1);
        recv_byte(1'b1, d); check("R10 read from zero", 32'(d), 32'h40);
        bus_stop();
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write_seq();
        t_read_rs();
        t_current_read();
        t_wrap_freeze();
        t_bad_addr();
        t_stop_abort();
        t_power();
        check("R12 oe rose only with scl low", 32'(oe_bad), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule